// File: doc/BRIEF.md
# Shared-Generator PWM Bank

This block holds a small pool of eight waveform generators and lets up to 33 output pins draw on them. The first 16 pins are direct outputs. The other 17 are handed as per-pin levels to a separate shift-out stage. Each generator has a period setting and an 8-bit high count. Each pin has a map entry made of an enable bit and a generator select. Pins that select the same generator show the same waveform, so one waveform can serve several pins.

A generator splits its period into 255 equal sub-steps. A prescale counter sets the length of each sub-step in clock cycles. The output is high for the first sub-steps, as many as the high count, and low for the rest of the period. Only normal polarity is provided.

Software programs the block through a simple word-addressed register bus. A new period or high count never cuts the running period short. Each generator picks up its new settings only when its current period ends. In a real system the clock is a slow timebase, so the period range stretches to milliseconds and seconds.

Top module: `pwm_share_bank`

## Requirements
- R1: After reset every pin output is low and every register reads as zero.
- R2: Registers read back the last value written. Word 0 holds the period fields of generators 0..3 and word 1 those of generators 4..7, 8 bits each, with generator 4k+j at bits 8j+7:8j. Words 2..5 hold the duty fields, with generator 2k+j in word 2+k at bits 16j+15:16j. Inside that field, bits 7:0 are the high count and bits 15:8 are the low count. Words 6..10 hold the pin map, with pin 8k+j in word 6+k at bits 4j+3:4j. In each entry, bit 3 is the enable and bits 2:0 are the generator select. Read data appears on `rdata` in the cycle after `rd_en` and holds until the next read. Unmapped addresses and bits read as zero.
- R3: For a period field P, an enabled pin repeats every 255*max(P,1) clock cycles.
- R4: For a high count h with 0<h<255, the pin is high for h*max(P,1) cycles at the start of each period and low for the rest.
- R5: A high count of 255 gives a constant high output, whatever the period.
- R6: A high count of 0 gives a constant low output.
- R7: A pin whose enable bit is clear is driven low.
- R8: Pins that select the same generator, on the direct group or the serial group, show the same waveform.
- R9: A write to a period or high count does not change the period that is running. The new values take effect from the next period start.
- R10: The low-count field is stored for readback only and has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock and sub-step timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| direct_out | output | 16 | Levels of the direct pins 0..15 |
| serial_lvl | output | 17 | Levels of pins 16..32 for the shift-out stage |

## Verification
The assertions assume that the read and write strobes are sampled on clean clock edges and that `addr` and `wdata` are stable when a strobe is high. They also assume that the reset is held for at least one edge before it is released. The stimulus drives every bus signal on the falling clock edge, makes only one access per cycle, and samples all outputs on the falling edge. Waveforms are judged by counting the cycles between observed edges, so the checks do not rely on the register delay from a generator to a pin. Each measurement skips one period after a reconfiguration, so a deferred update is never mistaken for a failure.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int GEN_COUNT     = 8;
  localparam int DIRECT_COUNT  = 16;
  localparam int SERIAL_COUNT  = 17;
  localparam int PER_FIELD_W   = 8;
  localparam int HIGH_FIELD_W  = 8;
  localparam int BUS_DATA_W    = 32;
  localparam int BUS_ADDR_W    = 4;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs #(
  parameter int NUM_GEN = 8,
  parameter int NUM_PIN = 33,
  parameter int PER_W   = 8,
  parameter int HIGH_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int SEL_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic [NUM_GEN-1:0][PER_W-1:0]   per_cfg,
  output logic [NUM_GEN-1:0][HIGH_W-1:0]  high_cfg,
  output logic [NUM_PIN-1:0]              pin_en,
  output logic [NUM_PIN-1:0][SEL_W-1:0]   pin_sel
);
  localparam int PER_PER_REG  = DATA_W / PER_W;
  localparam int N_PER_REG    = (NUM_GEN + PER_PER_REG - 1) / PER_PER_REG;
  localparam int DUTY_W       = 2 * HIGH_W;
  localparam int DUTY_PER_REG = DATA_W / DUTY_W;
  localparam int N_DUTY_REG   = (NUM_GEN + DUTY_PER_REG - 1) / DUTY_PER_REG;
  localparam int ENT_W        = SEL_W + 1;
  localparam int PIN_PER_REG  = DATA_W / ENT_W;
  localparam int DUTY_BASE    = N_PER_REG;
  localparam int MAP_BASE     = DUTY_BASE + N_DUTY_REG;

  logic [NUM_GEN-1:0][PER_W-1:0]  per_q, per_d;
  logic [NUM_GEN-1:0][HIGH_W-1:0] high_q, high_d, low_q, low_d;
  logic [NUM_PIN-1:0]             en_q, en_d;
  logic [NUM_PIN-1:0][SEL_W-1:0]  sel_q, sel_d;
  logic [DATA_W-1:0]              rd_word, rdata_q;

  // write decode: next-state of every stored field
  always_comb begin
    per_d  = per_q;
    high_d = high_q;
    low_d  = low_q;
    en_d   = en_q;
    sel_d  = sel_q;
    for (int g = 0; g < NUM_GEN; g++) begin
      if (addr == ADDR_W'(g / PER_PER_REG))
        per_d[g] = wdata[(g % PER_PER_REG) * PER_W +: PER_W];
      if (addr == ADDR_W'(DUTY_BASE + g / DUTY_PER_REG)) begin
        high_d[g] = wdata[(g % DUTY_PER_REG) * DUTY_W +: HIGH_W];
        low_d[g]  = wdata[(g % DUTY_PER_REG) * DUTY_W + HIGH_W +: HIGH_W];
      end
    end
    for (int p = 0; p < NUM_PIN; p++) begin
      if (addr == ADDR_W'(MAP_BASE + p / PIN_PER_REG)) begin
        sel_d[p] = wdata[(p % PIN_PER_REG) * ENT_W +: SEL_W];
        en_d[p]  = wdata[(p % PIN_PER_REG) * ENT_W + SEL_W];
      end
    end
  end

  // read mux
  always_comb begin
    rd_word = '0;
    for (int g = 0; g < NUM_GEN; g++) begin
      if (addr == ADDR_W'(g / PER_PER_REG))
        rd_word[(g % PER_PER_REG) * PER_W +: PER_W] = per_q[g];
      if (addr == ADDR_W'(DUTY_BASE + g / DUTY_PER_REG)) begin
        rd_word[(g % DUTY_PER_REG) * DUTY_W +: HIGH_W]          = high_q[g];
        rd_word[(g % DUTY_PER_REG) * DUTY_W + HIGH_W +: HIGH_W] = low_q[g];
      end
    end
    for (int p = 0; p < NUM_PIN; p++) begin
      if (addr == ADDR_W'(MAP_BASE + p / PIN_PER_REG))
        rd_word[(p % PIN_PER_REG) * ENT_W +: ENT_W] = {en_q[p], sel_q[p]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      high_q <= '0;
      low_q  <= '0;
      en_q   <= '0;
      sel_q  <= '0;
    end else if (wr_en) begin
      per_q  <= per_d;
      high_q <= high_d;
      low_q  <= low_d;
      en_q   <= en_d;
      sel_q  <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_word;
  end

  assign rdata    = rdata_q;
  assign per_cfg  = per_q;
  assign high_cfg = high_q;
  assign pin_en   = en_q;
  assign pin_sel  = sel_q;

  // R2: read data only moves on a read strobe
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
  // R2: stored configuration only moves on a write strobe
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(per_q) && $stable(high_q) && $stable(en_q) && $stable(sel_q)));
endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen #(
  parameter int PER_W  = 8,
  parameter int HIGH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PER_W-1:0]  cfg_per,
  input  logic [HIGH_W-1:0] cfg_high,
  output logic              wave
);
  localparam int STEPS  = (1 << HIGH_W) - 1;
  localparam int STEP_W = HIGH_W;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);
  localparam logic [HIGH_W-1:0] FULL_HIGH = HIGH_W'(STEPS);

  logic [PER_W-1:0]  pre_q, pre_d, pre_lim;
  logic [PER_W-1:0]  act_per_q;
  logic [HIGH_W-1:0] act_high_q;
  logic [STEP_W-1:0] step_q, step_d;
  logic              sub_done, period_done;

  always_comb begin
    pre_lim     = (act_per_q == '0) ? '0 : act_per_q - PER_W'(1);
    sub_done    = (pre_q == pre_lim);
    period_done = sub_done && (step_q == LAST_STEP);
    pre_d       = sub_done ? '0 : pre_q + PER_W'(1);
    step_d      = period_done ? '0 : step_q + STEP_W'(1);
    wave        = (int'(step_q) < int'(act_high_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        step_q <= '0;
    else if (sub_done) step_q <= step_d;
  end

  // settings are adopted only at a period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_per_q  <= '0;
      act_high_q <= '0;
    end else if (period_done) begin
      act_per_q  <= cfg_per;
      act_high_q <= cfg_high;
    end
  end

  a_r3_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST_STEP);
  a_r3_sub_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sub_done |=> (pre_q == '0));
  a_r9_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    !period_done |=> ($stable(act_per_q) && $stable(act_high_q)));
  a_r5_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (act_high_q == FULL_HIGH) |-> wave);
  a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (act_high_q == '0) |-> !wave);
endmodule

// File: rtl/pwm_pin_route.sv
module pwm_pin_route #(
  parameter int NUM_GEN = 8,
  parameter int NUM_PIN = 33,
  parameter int SEL_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_GEN-1:0]             wave,
  input  logic [NUM_PIN-1:0]             pin_en,
  input  logic [NUM_PIN-1:0][SEL_W-1:0]  pin_sel,
  output logic [NUM_PIN-1:0]             pin_lvl
);
  localparam int WAVE_PAD = 1 << SEL_W;

  logic [WAVE_PAD-1:0] wave_ext;
  logic [NUM_PIN-1:0]  lvl_d;

  assign wave_ext = WAVE_PAD'(wave);

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    assign lvl_d[p] = pin_en[p] && wave_ext[pin_sel[p]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_lvl <= '0;
    else        pin_lvl <= lvl_d;
  end

  // R7: a pin whose enable was clear on the previous edge is low
  a_r7_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_lvl & ~$past(pin_en)) == '0);
endmodule

// File: rtl/pwm_share_bank.sv
module pwm_share_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_GEN    = GEN_COUNT,
  parameter int NUM_DIRECT = DIRECT_COUNT,
  parameter int NUM_SERIAL = SERIAL_COUNT,
  parameter int PER_W      = PER_FIELD_W,
  parameter int HIGH_W     = HIGH_FIELD_W,
  parameter int DATA_W     = BUS_DATA_W,
  parameter int ADDR_W     = BUS_ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic [NUM_DIRECT-1:0] direct_out,
  output logic [NUM_SERIAL-1:0] serial_lvl
);
  localparam int NUM_PIN = NUM_DIRECT + NUM_SERIAL;
  localparam int SEL_W   = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;

  logic [1:0]                     rst_sync_q;
  logic                           core_rst_n;
  logic [NUM_GEN-1:0][PER_W-1:0]  per_cfg;
  logic [NUM_GEN-1:0][HIGH_W-1:0] high_cfg;
  logic [NUM_PIN-1:0]             pin_en;
  logic [NUM_PIN-1:0][SEL_W-1:0]  pin_sel;
  logic [NUM_GEN-1:0]             wave;
  logic [NUM_PIN-1:0]             pin_lvl;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  pwm_cfg_regs #(
    .NUM_GEN(NUM_GEN), .NUM_PIN(NUM_PIN), .PER_W(PER_W), .HIGH_W(HIGH_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(core_rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .per_cfg(per_cfg), .high_cfg(high_cfg), .pin_en(pin_en), .pin_sel(pin_sel)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    pwm_wavegen #(.PER_W(PER_W), .HIGH_W(HIGH_W)) u_gen (
      .clk(clk), .rst_n(core_rst_n),
      .cfg_per(per_cfg[g]), .cfg_high(high_cfg[g]), .wave(wave[g])
    );
  end

  pwm_pin_route #(.NUM_GEN(NUM_GEN), .NUM_PIN(NUM_PIN), .SEL_W(SEL_W)) u_route (
    .clk(clk), .rst_n(core_rst_n), .wave(wave),
    .pin_en(pin_en), .pin_sel(pin_sel), .pin_lvl(pin_lvl)
  );

  assign direct_out = pin_lvl[NUM_DIRECT-1:0];
  assign serial_lvl = pin_lvl[NUM_PIN-1:NUM_DIRECT];

  // R1: while the core is in reset no pin is driven high
  a_r1_reset_quiet: assert property (@(posedge clk)
    !core_rst_n |=> (pin_lvl == '0) || !core_rst_n);
endmodule

// File: tb/tb_pwm_share_bank.sv
module tb_pwm_share_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 11;

  typedef struct packed {
    logic [7:0] gen;
    logic [7:0] per;
    logic [7:0] high;
    logic [7:0] pin;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{gen: 8'd0, per: 8'd1, high: 8'd100, pin: 8'd0},
    '{gen: 8'd1, per: 8'd2, high: 8'd10,  pin: 8'd5},
    '{gen: 8'd2, per: 8'd3, high: 8'd200, pin: 8'd16},
    '{gen: 8'd3, per: 8'd0, high: 8'd50,  pin: 8'd32},
    '{gen: 8'd5, per: 8'd1, high: 8'd1,   pin: 8'd20},
    '{gen: 8'd7, per: 8'd2, high: 8'd254, pin: 8'd15}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] direct_out;
  logic [16:0] serial_lvl;

  int checks = 0;
  int failures = 0;
  logic [31:0] sh [NREG];
  int m_hi, m_tot;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_share_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .direct_out(direct_out), .serial_lvl(serial_lvl)
  );

  function automatic logic pin_at(int i);
    if (i < 16) return direct_out[i];
    return serial_lvl[i-16];
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < NREG) sh[a] = d;
  endtask

  task automatic rreg(int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = 4'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_period(int g, int p);
    logic [31:0] w;
    w = sh[g/4];
    w[8*(g%4) +: 8] = 8'(p);
    wreg(g/4, w);
  endtask

  task automatic set_duty(int g, int h);
    logic [31:0] w;
    w = sh[2 + g/2];
    w[16*(g%2) +: 16] = {8'(255 - h), 8'(h)};
    wreg(2 + g/2, w);
  endtask

  task automatic set_map(int pin, bit en, int sel);
    logic [31:0] w;
    w = sh[6 + pin/8];
    w[4*(pin%8) +: 4] = {en, 3'(sel)};
    wreg(6 + pin/8, w);
  endtask

  task automatic wait_rise(int pin, output bit ok);
    logic prev;
    ok = 1'b0;
    @(negedge clk);
    prev = pin_at(pin);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!prev && pin_at(pin)) begin ok = 1'b1; break; end
      prev = pin_at(pin);
    end
  endtask

  // skips one period start, then counts high and total cycles of the next period
  task automatic measure(int pin, output int hi, output int tot);
    bit ok;
    int lo;
    hi = -1; tot = -1;
    wait_rise(pin, ok);
    if (!ok) return;
    wait_rise(pin, ok);
    if (!ok) return;
    hi = 1;
    while (1) begin
      @(negedge clk);
      if (!pin_at(pin)) break;
      hi++;
      if (hi > 4000) return;
    end
    lo = 1;
    while (1) begin
      @(negedge clk);
      if (pin_at(pin)) break;
      lo++;
      if (lo > 4000) return;
    end
    tot = hi + lo;
  endtask

  task automatic count_level(int pin, int n, output int seen_high);
    seen_high = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin_at(pin)) seen_high++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int mismatch;
    int pe, hcnt, lcnt, tcnt, nh;
    for (int i = 0; i < NREG; i++) sh[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 direct pins low", int'(direct_out), 0);
    chk("R1 serial pins low", int'(serial_lvl), 0);
    mismatch = 0;
    for (int a = 0; a < NREG; a++) begin
      rreg(a, rd);
      if (rd != '0) mismatch++;
    end
    chk("R1 registers zero", mismatch, 0);

    // R3 R4: vector table
    for (int v = 0; v < 6; v++) begin
      pe = (VEC[v].per == 0) ? 1 : int'(VEC[v].per);
      set_period(int'(VEC[v].gen), int'(VEC[v].per));
      set_duty(int'(VEC[v].gen), int'(VEC[v].high));
      set_map(int'(VEC[v].pin), 1'b1, int'(VEC[v].gen));
      measure(int'(VEC[v].pin), m_hi, m_tot);
      chk($sformatf("R4 high time vec%0d", v), m_hi, int'(VEC[v].high) * pe);
      chk($sformatf("R3 period vec%0d", v), m_tot, 255 * pe);
    end

    // R8: a direct and a serial pin sharing generator 1 (P=2, h=10)
    set_map(1, 1'b1, 1);
    set_map(30, 1'b1, 1);
    measure(1, m_hi, m_tot);
    chk("R8 direct share high", m_hi, 20);
    chk("R8 direct share period", m_tot, 510);
    measure(30, m_hi, m_tot);
    chk("R8 serial share high", m_hi, 20);
    chk("R8 serial share period", m_tot, 510);

    // R10: corrupt low field of generator 1, waveform unchanged
    begin
      logic [31:0] w;
      w = sh[2];
      w[31:24] = 8'h00;
      wreg(2, w);
    end
    measure(5, m_hi, m_tot);
    chk("R10 low field ignored high", m_hi, 20);
    chk("R10 low field ignored period", m_tot, 510);

    // R2: readback of every register and an unmapped address
    mismatch = 0;
    for (int a = 0; a < NREG; a++) begin
      rreg(a, rd);
      if (rd != sh[a]) begin
        mismatch++;
        $display("FAIL R2 addr=%0d actual=%h expected=%h", a, rd, sh[a]);
      end
    end
    chk("R2 readback mismatches", mismatch, 0);
    wreg(13, 32'hDEAD_BEEF);
    rreg(13, rd);
    chk("R2 unmapped reads zero", int'(rd), 0);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R2 rdata holds without read", int'(rdata), 0);

    // R5: full-scale high count on generator 4, pin 2
    set_period(4, 1);
    set_duty(4, 255);
    set_map(2, 1'b1, 4);
    repeat (300) @(negedge clk);
    count_level(2, 600, nh);
    chk("R5 constant high", nh, 600);

    // R6: zero high count on generator 6, pin 3
    set_period(6, 1);
    set_duty(6, 0);
    set_map(3, 1'b1, 6);
    repeat (300) @(negedge clk);
    count_level(3, 600, nh);
    chk("R6 constant low", nh, 0);

    // R7: disable pin 0 (generator 0 still running)
    set_map(0, 1'b0, 0);
    repeat (3) @(negedge clk);
    count_level(0, 600, nh);
    chk("R7 disabled pin low", nh, 0);
    measure(15, m_hi, m_tot);
    chk("R7 other pin unaffected", m_hi, 508);

    // R9: deferred update on generator 2 (P=3, h=200), pin 16
    begin
      bit ok;
      logic [31:0] wp, wd;
      wait_rise(16, ok);
      wp = sh[0]; wp[23:16] = 8'd1;
      wd = sh[3]; wd[15:0] = {8'd235, 8'd20};
      hcnt = 1;
      for (int c = 0; c < 12; c++) begin
        if (c == 10) begin wr_en = 1'b1; addr = 4'd0; wdata = wp; end
        if (c == 11) begin wr_en = 1'b1; addr = 4'd3; wdata = wd; end
        @(negedge clk);
        if (pin_at(16)) hcnt++;
      end
      wr_en = 1'b0;
      sh[0] = wp; sh[3] = wd;
      while (pin_at(16) && hcnt < 4000) begin
        @(negedge clk);
        if (pin_at(16)) hcnt++;
      end
      lcnt = 0;
      while (!pin_at(16) && lcnt < 4000) begin
        lcnt++;
        @(negedge clk);
      end
      tcnt = hcnt + lcnt;
      chk("R9 running high kept", hcnt, 600);
      chk("R9 running period kept", tcnt, 765);
      hcnt = 1;
      @(negedge clk);
      while (pin_at(16) && hcnt < 4000) begin
        hcnt++;
        @(negedge clk);
      end
      chk("R9 new high next period", hcnt, 20);
      measure(16, m_hi, m_tot);
      chk("R9 new period", m_tot, 255);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule